// File: doc/BRIEF.md
# DMA Descriptor Checker and Decoder

This block receives a sixteen-word DMA descriptor, one 32-bit word per cycle, and turns it into a verdict plus a set of decoded transfer parameters. It checks the descriptor in a fixed order and reports only the first failure. The checks cover a marker byte in the control word, an optional additive checksum over the first fifteen words, and a completion flag that shows the descriptor has already been consumed. The decoded side gives the transfer size, the descriptor identifier, the line size, the line stride in bytes and a packed video word. It also gives the 48-bit next-descriptor pointer, five 48-bit source addresses, the per-fragment byte counts for fragmented mode, and a packed status word for a channel status register.

A fetch engine drives the words in order. It marks the first word of each descriptor with `in_first` and may leave idle cycles between words. One cycle after the last word is accepted, `out_valid` pulses and all other outputs describe that descriptor. A new first word at any point throws away a partly received descriptor and its running checksum.

Top module: `desc_checker`

## Requirements
- R1: The descriptor passes the marker check only when word 0 bits [7:0] equal 0xA5. Otherwise out_err is 1 (marker error).
- R2: When word 0 bit 20 is set, the 32-bit wrapping sum of words 0 to 14 must equal word 15, or out_err is 2 (checksum error). When bit 20 is clear, word 15 has no effect on the verdict.
- R3: When word 5 bit 31 (done) is set and word 0 bit 10 (ignore-done) is clear, out_err is 3 (reuse error). When bit 10 is set, the done bit causes no error.
- R4: The marker check has the highest priority, then the checksum check, then the reuse check. out_err is 0 and out_pass is 1 only when no check fails.
- R5: out_line is word 3 bits [17:0]. out_stride is word 3 bits [31:18] times 16. out_video is word 3 bits [31:18] in bits [13:0], with word 3 bits [17:0] in bits [31:14].
- R6: out_size is word 2 and out_id is word 1. out_next is {word 6 [15:0], word 7}. Source address k (out_src bits [48k+47:48k]) is: {word 6 [31:16], word 8} for k=0; {word 9 [15:0], word 11} for k=1; {word 9 [31:16], word 12} for k=2; {word 10 [15:0], word 13} for k=3; {word 10 [31:16], word 14} for k=4.
- R7: out_status bits [20:13] hold word 0 bits [7:0]. Control bits map to status bits 8→12, 9→11, 10→9, 21→8, 19→7, 20→6, 18→5 and 11→4. Word 5 bit 31 maps to status bit 10. All other status bits are 0.
- R8: out_frag_mode is word 0 bit 18. In fragmented mode, fragment length k (out_frag_len bits [13k+12:13k]) is 4096 minus the low 12 bits of source address k, which gives 4096 for an aligned address. In contiguous mode every fragment length is 0.
- R9: out_valid is high for exactly one cycle: the cycle after the clock edge that accepts word 15 of a descriptor. It is low at all other times.
- R10: A word with in_first set is taken as word 0 and discards any partial descriptor and partial checksum. Cycles with in_valid low leave the word position and the sum unchanged.
- R11: During reset and immediately after it, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A descriptor word is present |
| in_first | input | 1 | Word is word 0 of a new descriptor |
| in_word | input | 32 | Descriptor word, little-endian order already resolved |
| out_valid | output | 1 | One-cycle pulse: outputs describe the last descriptor |
| out_pass | output | 1 | All checks passed |
| out_err | output | 2 | 0 none, 1 marker, 2 checksum, 3 reuse |
| out_size | output | 32 | Transfer size in bytes |
| out_id | output | 32 | Descriptor identifier |
| out_line | output | 18 | Line size in bytes |
| out_stride | output | 18 | Line stride in bytes |
| out_video | output | 32 | Packed stride field and line size |
| out_next | output | 48 | Next-descriptor pointer |
| out_src | output | 240 | Five 48-bit source addresses, address 0 lowest |
| out_frag_len | output | 65 | Five 13-bit fragment byte counts |
| out_frag_mode | output | 1 | 1 fragmented, 0 contiguous |
| out_status | output | 32 | Packed channel status word |

## Verification
Every result falls due in the single cycle that follows the edge accepting word 15, because one register stage separates the last word from `out_valid` and the decoded fields come straight from the stored words. The bench drives each input on a falling edge and, before it drives the next input, samples the outputs on the following falling edge. A reference model tracks the word position and predicts for every cycle whether `out_valid` is due. It compares the verdict and every decoded field only in the predicted cycle. Idle gaps, restarts partway through a descriptor and back-to-back descriptors move the due cycle, and the model follows each of those changes.

// File: rtl/desc_pkg.sv
package desc_pkg;

    localparam int WORD_W     = 32;
    localparam int N_WORDS    = 16;
    localparam int IDX_W      = $clog2(N_WORDS);
    localparam int EXT_W      = 16;
    localparam int ADDR_W     = WORD_W + EXT_W;
    localparam int N_SRC      = 5;
    localparam int LINE_W     = 18;
    localparam int STEP_FLD_W = WORD_W - LINE_W;
    localparam int STEP_SHIFT = 4;
    localparam int STRIDE_W   = STEP_FLD_W + STEP_SHIFT;
    localparam int FRAG_BYTES = 4096;
    localparam int FRAG_OFF_W = $clog2(FRAG_BYTES);
    localparam int FRAG_LEN_W = FRAG_OFF_W + 1;
    localparam int MARK_W     = 8;
    localparam logic [MARK_W-1:0] MARK = 8'hA5;

    // word positions inside a descriptor
    localparam int W_CTRL  = 0;
    localparam int W_ID    = 1;
    localparam int W_SIZE  = 2;
    localparam int W_LINE  = 3;
    localparam int W_STAMP = 5;
    localparam int W_EXTA  = 6;
    localparam int W_NEXT  = 7;
    localparam int W_SRC0  = 8;
    localparam int W_EXTB  = 9;
    localparam int W_CHECK = 15;

    // control word bits
    localparam int CB_IRQ    = 8;
    localparam int CB_UPD    = 9;
    localparam int CB_IGN    = 10;
    localparam int CB_FIXED  = 11;
    localparam int CB_MODE   = 18;
    localparam int CB_LAST   = 19;
    localparam int CB_SUM    = 20;
    localparam int CB_LASTFR = 21;
    localparam int DONE_BIT  = 31;

    // status word bits
    localparam int ST_MARK_LSB = 13;
    localparam int ST_IRQ   = 12;
    localparam int ST_UPD   = 11;
    localparam int ST_DONE  = 10;
    localparam int ST_IGN   = 9;
    localparam int ST_LFR   = 8;
    localparam int ST_LAST  = 7;
    localparam int ST_SUM   = 6;
    localparam int ST_MODE  = 5;
    localparam int ST_FIXED = 4;

    typedef logic [N_WORDS-1:0][WORD_W-1:0] desc_words_t;

    typedef enum logic [1:0] {
        VERD_OK     = 2'd0,
        VERD_MARK   = 2'd1,
        VERD_SUM    = 2'd2,
        VERD_REUSED = 2'd3
    } verdict_e;

    typedef struct packed {
        logic [WORD_W-1:0]                  size;
        logic [WORD_W-1:0]                  id;
        logic [LINE_W-1:0]                  line;
        logic [STRIDE_W-1:0]                stride;
        logic [WORD_W-1:0]                  video;
        logic [ADDR_W-1:0]                  next_ptr;
        logic [N_SRC-1:0][ADDR_W-1:0]       src;
        logic [N_SRC-1:0][FRAG_LEN_W-1:0]   frag_len;
        logic                               frag_mode;
        logic [WORD_W-1:0]                  status;
    } desc_fields_t;

    function automatic logic [FRAG_LEN_W-1:0] span_to_boundary(
        input logic [FRAG_OFF_W-1:0] off);
        return FRAG_LEN_W'(FRAG_BYTES) - {1'b0, off};
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(
        input logic [WORD_W-1:0] ctrl, input logic done);
        logic [WORD_W-1:0] st;
        st = '0;
        st[ST_MARK_LSB +: MARK_W] = ctrl[MARK_W-1:0];
        st[ST_IRQ]   = ctrl[CB_IRQ];
        st[ST_UPD]   = ctrl[CB_UPD];
        st[ST_DONE]  = done;
        st[ST_IGN]   = ctrl[CB_IGN];
        st[ST_LFR]   = ctrl[CB_LASTFR];
        st[ST_LAST]  = ctrl[CB_LAST];
        st[ST_SUM]   = ctrl[CB_SUM];
        st[ST_MODE]  = ctrl[CB_MODE];
        st[ST_FIXED] = ctrl[CB_FIXED];
        return st;
    endfunction

endpackage

// File: rtl/desc_capture.sv
module desc_capture
    import desc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                in_first,
    input  logic [WORD_W-1:0]   in_word,
    output desc_words_t         words_o,
    output logic [WORD_W-1:0]   sum_o,
    output logic                complete_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  eff_idx;
    logic [WORD_W-1:0] sum_q;
    desc_words_t       words_q;

    assign eff_idx = in_first ? '0 : idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q      <= '0;
            sum_q      <= '0;
            complete_o <= 1'b0;
        end else begin
            complete_o <= in_valid && (eff_idx == LAST_IDX);
            if (in_valid) begin
                idx_q <= (eff_idx == LAST_IDX) ? '0 : eff_idx + 1'b1;
                if (eff_idx == '0)
                    sum_q <= in_word;
                else if (eff_idx != LAST_IDX)
                    sum_q <= sum_q + in_word;
            end
        end
    end

    for (genvar g = 0; g < N_WORDS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                words_q[g] <= '0;
            else if (in_valid && eff_idx == IDX_W'(g))
                words_q[g] <= in_word;
        end
    end

    assign words_o = words_q;
    assign sum_o   = sum_q;

    // R10: a restart seeds the sum with the new first word only
    a_r10_restart_sum: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_first) |=> (sum_q == $past(in_word)));

    // R10: idle cycles leave the running sum alone
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(sum_q));

endmodule

// File: rtl/desc_verify.sv
module desc_verify
    import desc_pkg::*;
(
    input  logic [MARK_W-1:0]  mark,
    input  logic               sum_en,
    input  logic               ignore_done,
    input  logic               done,
    input  logic [WORD_W-1:0]  sum,
    input  logic [WORD_W-1:0]  check,
    output verdict_e           verdict
);
    always_comb begin
        if (mark != MARK)
            verdict = VERD_MARK;
        else if (sum_en && (sum != check))
            verdict = VERD_SUM;
        else if (done && !ignore_done)
            verdict = VERD_REUSED;
        else
            verdict = VERD_OK;
    end
endmodule

// File: rtl/desc_decode.sv
module desc_decode
    import desc_pkg::*;
(
    input  desc_words_t   words,
    output desc_fields_t  fields
);
    logic [WORD_W-1:0] ctrl;
    logic [WORD_W-1:0] geom;
    logic              stamp_unused;

    assign ctrl = words[W_CTRL];
    assign geom = words[W_LINE];
    assign stamp_unused = ^{words[4], words[W_STAMP][DONE_BIT-1:0], words[W_CHECK]};

    assign fields.size      = words[W_SIZE];
    assign fields.id        = words[W_ID];
    assign fields.line      = geom[LINE_W-1:0];
    assign fields.stride    = {geom[WORD_W-1:LINE_W], STEP_SHIFT'(0)};
    assign fields.video     = {geom[LINE_W-1:0], geom[WORD_W-1:LINE_W]};
    assign fields.next_ptr  = {words[W_EXTA][EXT_W-1:0], words[W_NEXT]};
    assign fields.frag_mode = ctrl[CB_MODE];
    assign fields.status    = pack_status(ctrl, words[W_STAMP][DONE_BIT]);

    for (genvar k = 0; k < N_SRC; k++) begin : g_src
        localparam int EXT_IDX  = (k == 0) ? W_EXTA : W_EXTB + (k - 1) / 2;
        localparam int EXT_HALF = (k == 0) ? 1 : (k - 1) % 2;
        localparam int LOW_IDX  = (k == 0) ? W_SRC0 : W_SRC0 + 2 + k;
        logic [ADDR_W-1:0] addr;
        assign addr = {words[EXT_IDX][EXT_HALF*EXT_W +: EXT_W], words[LOW_IDX]};
        assign fields.src[k] = addr;
        assign fields.frag_len[k] = ctrl[CB_MODE] ?
            span_to_boundary(addr[FRAG_OFF_W-1:0]) : '0;
    end
endmodule

// File: rtl/desc_checker.sv
module desc_checker
    import desc_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic                          in_first,
    input  logic [WORD_W-1:0]             in_word,
    output logic                          out_valid,
    output logic                          out_pass,
    output logic [1:0]                    out_err,
    output logic [WORD_W-1:0]             out_size,
    output logic [WORD_W-1:0]             out_id,
    output logic [LINE_W-1:0]             out_line,
    output logic [STRIDE_W-1:0]           out_stride,
    output logic [WORD_W-1:0]             out_video,
    output logic [ADDR_W-1:0]             out_next,
    output logic [N_SRC*ADDR_W-1:0]       out_src,
    output logic [N_SRC*FRAG_LEN_W-1:0]   out_frag_len,
    output logic                          out_frag_mode,
    output logic [WORD_W-1:0]             out_status
);
    desc_words_t       words;
    logic [WORD_W-1:0] sum;
    logic              complete;
    verdict_e          verdict;
    desc_fields_t      fields;

    desc_capture u_capture (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_first   (in_first),
        .in_word    (in_word),
        .words_o    (words),
        .sum_o      (sum),
        .complete_o (complete)
    );

    desc_verify u_verify (
        .mark        (words[W_CTRL][MARK_W-1:0]),
        .sum_en      (words[W_CTRL][CB_SUM]),
        .ignore_done (words[W_CTRL][CB_IGN]),
        .done        (words[W_STAMP][DONE_BIT]),
        .sum         (sum),
        .check       (words[W_CHECK]),
        .verdict     (verdict)
    );

    desc_decode u_decode (
        .words  (words),
        .fields (fields)
    );

    assign out_valid     = complete;
    assign out_err       = verdict;
    assign out_pass      = (verdict == VERD_OK);
    assign out_size      = fields.size;
    assign out_id        = fields.id;
    assign out_line      = fields.line;
    assign out_stride    = fields.stride;
    assign out_video     = fields.video;
    assign out_next      = fields.next_ptr;
    assign out_src       = fields.src;
    assign out_frag_len  = fields.frag_len;
    assign out_frag_mode = fields.frag_mode;
    assign out_status    = fields.status;

    // R9: the result pulse never lasts two cycles
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R9: a result follows an accepted word
    a_r9_after_word: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R1: getting past the marker check means the status carries the marker
    a_r1_marker_seen: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_err != VERD_MARK) |-> (out_status[ST_MARK_LSB +: MARK_W] == MARK));

    // R2: a checksum verdict needs the checksum enable in the status
    a_r2_sum_enabled: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_err == VERD_SUM) |-> out_status[ST_SUM]);

    // R3: a reuse verdict needs done set and ignore-done clear
    a_r3_reuse_flags: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_err == VERD_REUSED) |-> (out_status[ST_DONE] && !out_status[ST_IGN]));

endmodule

// File: tb/desc_checker_tb.sv
module desc_checker_tb;
    localparam int CLK_NS = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_first = 1'b0;
    logic [31:0] in_word = '0;
    logic out_valid, out_pass, out_frag_mode;
    logic [1:0] out_err;
    logic [31:0] out_size, out_id, out_video, out_status;
    logic [17:0] out_line, out_stride;
    logic [47:0] out_next;
    logic [239:0] out_src;
    logic [64:0] out_frag_len;

    always #(CLK_NS/2) clk = ~clk;

    desc_checker u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
        .in_word(in_word), .out_valid(out_valid), .out_pass(out_pass),
        .out_err(out_err), .out_size(out_size), .out_id(out_id),
        .out_line(out_line), .out_stride(out_stride), .out_video(out_video),
        .out_next(out_next), .out_src(out_src), .out_frag_len(out_frag_len),
        .out_frag_mode(out_frag_mode), .out_status(out_status)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // reference model state
    logic [31:0] cur [16];
    logic [31:0] snap [16];
    logic [31:0] dsc [16];
    int  pos = 0;
    bit  exp_v = 0;
    string scen_req = "R4";

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare_now();
        logic [31:0] s;
        logic [1:0]  e;
        logic [31:0] st;
        logic [15:0] ext;
        logic [47:0] a;
        int from_b [8];
        int to_b   [8];
        from_b = '{8, 9, 10, 21, 19, 20, 18, 11};
        to_b   = '{12, 11, 9, 8, 7, 6, 5, 4};
        chk("R9 valid timing", 64'(out_valid), 64'(exp_v));
        if (exp_v) begin
            s = 0;
            for (int i = 0; i < 15; i++) s = s + snap[i];
            if (snap[0][7:0] != 8'hA5) e = 1;
            else if (snap[0][20] && s != snap[15]) e = 2;
            else if (snap[5][31] && !snap[0][10]) e = 3;
            else e = 0;
            chk({scen_req, " verdict"}, 64'(out_err), 64'(e));
            chk("R4 pass flag", 64'(out_pass), 64'(e == 0));
            chk("R6 size", 64'(out_size), 64'(snap[2]));
            chk("R6 id", 64'(out_id), 64'(snap[1]));
            chk("R6 next pointer", 64'(out_next), {16'h0, snap[6][15:0], snap[7]});
            chk("R5 line", 64'(out_line), 64'(snap[3] & 32'h3FFFF));
            chk("R5 stride", 64'(out_stride), 64'((snap[3] >> 18) * 16));
            chk("R5 video", 64'(out_video), 64'({snap[3][17:0], 14'h0} | (snap[3] >> 18)));
            st = 0;
            st[20:13] = snap[0][7:0];
            for (int i = 0; i < 8; i++) st[to_b[i]] = snap[0][from_b[i]];
            st[10] = snap[5][31];
            chk("R7 status", 64'(out_status), 64'(st));
            chk("R8 mode", 64'(out_frag_mode), 64'(snap[0][18]));
            for (int k = 0; k < 5; k++) begin
                if (k == 0) ext = snap[6][31:16];
                else if (k % 2 == 1) ext = snap[9 + (k - 1) / 2][15:0];
                else ext = snap[9 + (k - 1) / 2][31:16];
                a = {ext, snap[(k == 0) ? 8 : 10 + k]};
                chk("R6 source address", 64'(out_src[48*k +: 48]), 64'(a));
                chk("R8 fragment length", 64'(out_frag_len[13*k +: 13]),
                    snap[0][18] ? 64'(4096 - (a % 4096)) : 64'd0);
            end
        end
    endtask

    task automatic step(input bit v, input bit f, input logic [31:0] w);
        @(negedge clk);
        compare_now();
        in_valid = v;
        in_first = f;
        in_word  = w;
        exp_v = 0;
        if (v) begin
            if (f) pos = 0;
            cur[pos] = w;
            if (pos == 15) begin
                exp_v = 1;
                snap = cur;
            end
            pos = (pos + 1) % 16;
        end
    endtask

    task automatic make(input logic [31:0] ctrl, input bit done, input logic [31:0] seed);
        for (int i = 0; i < 16; i++) dsc[i] = (32'h9E3779B9 * 32'(i + 1)) ^ seed;
        dsc[0] = ctrl;
        dsc[5][31] = done;
    endtask

    task automatic fin(input bit good_sum);
        logic [31:0] s;
        s = 0;
        for (int i = 0; i < 15; i++) s = s + dsc[i];
        dsc[15] = good_sum ? s : s + 32'd1;
    endtask

    task automatic send(input bit gap);
        for (int i = 0; i < 16; i++) begin
            step(1'b1, i == 0, dsc[i]);
            if (gap && (i == 4 || i == 11)) step(1'b0, 1'b0, 32'hDEAD_BEEF);
        end
    endtask

    localparam logic [31:0] MK   = 32'h0000_00A5;
    localparam logic [31:0] SUM  = 32'h0010_0000;
    localparam logic [31:0] IGN  = 32'h0000_0400;
    localparam logic [31:0] MODE = 32'h0004_0000;

    initial begin
        #(CLK_NS * 100000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset valid", 64'(out_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 after reset", 64'(out_valid), 64'd0);

        // R2: checksum disabled, wrong word 15 ignored; flags R7
        scen_req = "R2"; make(MK | 32'h0000_0900, 0, 32'h1234_5678); fin(0); send(0);
        // R2: checksum enabled and correct, sum wraps
        scen_req = "R2"; make(MK | SUM | 32'h0008_0200, 0, 32'hF0F0_0F0F); fin(1); send(0);
        // R2: checksum enabled and wrong
        scen_req = "R2"; make(MK | SUM, 0, 32'h0BAD_0001); fin(0); send(0);
        // R4: bad marker beats bad checksum
        scen_req = "R4"; make(32'h0000_005A | SUM, 1, 32'h5555_AAAA); fin(0); send(0);
        // R4: bad checksum beats reuse
        scen_req = "R4"; make(MK | SUM, 1, 32'h0000_1111); fin(0); send(0);
        // R3: done set, ignore clear
        scen_req = "R3"; make(MK, 1, 32'h2222_0000); fin(1); send(0);
        // R3: done set, ignore set
        scen_req = "R3"; make(MK | IGN, 1, 32'h3333_0000); fin(1); send(0);
        // R1: marker off by one
        scen_req = "R1"; make(32'h0000_00A4, 0, 32'h4444_0000); fin(1); send(0);
        // R8: fragmented, one aligned address, R7 last-of-frame bit
        scen_req = "R8"; make(MK | MODE | 32'h0020_0000, 0, 32'h0000_0ABC);
        dsc[8] = 32'h0001_0000; fin(1); send(0);
        // R10: idle gaps inside a descriptor
        scen_req = "R10"; make(MK | SUM, 0, 32'h6666_7777); fin(1); send(1);
        // R10: partial descriptor abandoned by a restart
        scen_req = "R10";
        make(MK, 1, 32'h7777_0000);
        for (int i = 0; i < 7; i++) step(1'b1, i == 0, dsc[i]);
        make(MK | SUM | MODE, 0, 32'h8888_1234); fin(1); send(0);
        // R10: restart right before word 15 would have completed
        make(MK, 0, 32'h9999_0000);
        for (int i = 0; i < 15; i++) step(1'b1, i == 0, dsc[i]);
        make(MK | SUM, 0, 32'hAAAA_0000); fin(1); send(0);
        step(1'b0, 1'b0, 32'h0);
        step(1'b0, 1'b0, 32'h0);
        step(1'b0, 1'b0, 32'h0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule